// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

This unit executes the five saturating arithmetic operations of a 32-bit integer pipeline: add of two registers, add of a sign-extended 5-bit immediate, subtract of two registers, reverse subtract, and subtract of a sign-extended 16-bit immediate from a separate source register. Decode has already produced the opcode, the register file has supplied both operand values, and the fetch stage has assembled both immediate fields. In the same cycle the unit returns the 32-bit result, a write enable for the destination register and the next values of the carry, overflow, sign and zero flags.

When the true signed result does not fit in 32 bits, the output clamps to the nearest representable extreme. A saturation event also sets a sticky saturation flag. That flag is held in a register inside the unit and stays set until reset or the dedicated clear input drops it. The flag output always shows the value that will be visible after the current cycle, so the pipeline can forward it.

Top module: `sat_arith_unit`

## Requirements
- R1: With `op_valid` high and `opcode` = 6'b000110, the unit produces saturate(`reg2_val` + `reg1_val`).
- R2: With `opcode` = 6'b010001, the unit produces saturate(`reg2_val` + sign-extended `imm_short`), where bit 4 of `imm_short` is the sign.
- R3: With `opcode` = 6'b000101, the unit produces saturate(`reg2_val` − `reg1_val`).
- R4: With `opcode` = 6'b000100, the unit produces saturate(`reg1_val` − `reg2_val`).
- R5: With `opcode` = 6'b110011, the unit produces saturate(`reg1_val` − sign-extended `imm_long`), where bit 15 of `imm_long` is the sign.
- R6: A positive signed overflow gives 0x7FFFFFFF and a negative one gives 0x80000000. `flag_ov` is 1 exactly when the result was clamped.
- R7: `flag_cy` is the unsigned carry out of an add, or the unsigned borrow of a subtract (1 when the minuend is smaller than the subtrahend as unsigned values). Both are taken from the unclamped operation.
- R8: `flag_s` equals bit 31 of the clamped result, and `flag_z` is 1 exactly when the clamped result is zero.
- R9: `wr_en` is 1 only when `op_valid` is high and the opcode is one of the five above. Otherwise `result`, `flag_cy`, `flag_ov`, `flag_s` and `flag_z` are 0 and the sticky flag is not set.
- R10: `flag_sat` = (stored sticky bit) OR (saturation in this cycle). The stored bit takes that value at each rising clock edge and is 0 after reset.
- R11: `clr_sat` high drops the stored sticky bit for the current cycle's `flag_sat` and for the stored value. A saturation in the same cycle still sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 6 | Decoded operation code |
| reg1_val | input | 32 | First register operand |
| reg2_val | input | 32 | Second register operand (also the destination's old value) |
| imm_short | input | 5 | Short signed immediate |
| imm_long | input | 16 | Long signed immediate |
| clr_sat | input | 1 | Drop the sticky saturation flag |
| result | output | 32 | Clamped result |
| wr_en | output | 1 | Destination register write enable |
| flag_cy | output | 1 | Next carry/borrow flag |
| flag_ov | output | 1 | Next overflow flag (saturation occurred) |
| flag_s | output | 1 | Next sign flag |
| flag_z | output | 1 | Next zero flag |
| flag_sat | output | 1 | Next sticky saturation flag |

## Verification
The clear of the sticky flag and a new saturation event can fall in the same cycle. That collision decides whether an overflow is lost. The bench drives `clr_sat` together with an overflowing add and expects `flag_sat` to stay 1 in that cycle and after the edge. It then repeats the clear with a non-overflowing add and expects 0 in both places.

// File: rtl/sat_pkg.sv
package sat_pkg;

   typedef enum logic [5:0] {
      OP_SADD  = 6'b000110,
      OP_SADDI = 6'b010001,
      OP_SSUB  = 6'b000101,
      OP_SSUBR = 6'b000100,
      OP_SSUBI = 6'b110011
   } sat_op_e;

   typedef struct packed {
      logic cy;
      logic ov;
      logic s;
      logic z;
   } sat_flags_t;

endpackage

// File: rtl/sat_operand_sel.sv
module sat_operand_sel
   import sat_pkg::*;
#(
   parameter int W     = 32,
   parameter int IMM_S = 5,
   parameter int IMM_L = 16
) (
   input  logic [5:0]       opcode,
   input  logic [W-1:0]     reg1_val,
   input  logic [W-1:0]     reg2_val,
   input  logic [IMM_S-1:0] imm_short,
   input  logic [IMM_L-1:0] imm_long,
   output logic [W-1:0]     opnd_a,
   output logic [W-1:0]     opnd_b,
   output logic             do_sub,
   output logic             known_op
);

   initial begin
      if (IMM_S < 1 || IMM_S > W) $error("sat_operand_sel: IMM_S out of range");
      if (IMM_L < 1 || IMM_L > W) $error("sat_operand_sel: IMM_L out of range");
   end

   logic [W-1:0] sext_short;
   logic [W-1:0] sext_long;

   generate
      if (IMM_S < W) begin : g_short_ext
         assign sext_short = {{(W-IMM_S){imm_short[IMM_S-1]}}, imm_short};
      end else begin : g_short_full
         assign sext_short = imm_short;
      end
      if (IMM_L < W) begin : g_long_ext
         assign sext_long = {{(W-IMM_L){imm_long[IMM_L-1]}}, imm_long};
      end else begin : g_long_full
         assign sext_long = imm_long;
      end
   endgenerate

   always_comb begin
      opnd_a   = '0;
      opnd_b   = '0;
      do_sub   = 1'b0;
      known_op = 1'b1;
      case (opcode)
         OP_SADD:  begin opnd_a = reg2_val; opnd_b = reg1_val;   end
         OP_SADDI: begin opnd_a = reg2_val; opnd_b = sext_short; end
         OP_SSUB:  begin opnd_a = reg2_val; opnd_b = reg1_val;   do_sub = 1'b1; end
         OP_SSUBR: begin opnd_a = reg1_val; opnd_b = reg2_val;   do_sub = 1'b1; end
         OP_SSUBI: begin opnd_a = reg1_val; opnd_b = sext_long;  do_sub = 1'b1; end
         default:  known_op = 1'b0;
      endcase
   end

endmodule

// File: rtl/sat_addsub_core.sv
module sat_addsub_core #(
   parameter int W = 32
) (
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   input  logic         do_sub,
   output logic [W-1:0] clamped,
   output logic         carry_flag,
   output logic         overflow
);

   initial begin
      if (W < 2) $error("sat_addsub_core: W must be at least 2");
   end

   localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] b_eff;
   logic [W:0]   raw_sum;

   assign b_eff      = do_sub ? ~opnd_b : opnd_b;
   assign raw_sum    = {1'b0, opnd_a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
   assign carry_flag = do_sub ? ~raw_sum[W] : raw_sum[W];
   assign overflow   = (opnd_a[W-1] == b_eff[W-1]) && (raw_sum[W-1] != opnd_a[W-1]);

   always_comb begin
      if (!overflow)         clamped = raw_sum[W-1:0];
      else if (opnd_a[W-1])  clamped = NEG_LIMIT;
      else                   clamped = POS_LIMIT;
   end

endmodule

// File: rtl/sat_sticky_flag.sv
module sat_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set_ev,
   output logic flag_next,
   output logic flag_q
);

   assign flag_next = (flag_q & ~clr) | set_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_next;
   end

   // R10
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);

   // R11
   clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_ev) |=> !flag_q);

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev |=> flag_q);

endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
   import sat_pkg::*;
#(
   parameter int W     = 32,
   parameter int IMM_S = 5,
   parameter int IMM_L = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [5:0]       opcode,
   input  logic [W-1:0]     reg1_val,
   input  logic [W-1:0]     reg2_val,
   input  logic [IMM_S-1:0] imm_short,
   input  logic [IMM_L-1:0] imm_long,
   input  logic             clr_sat,
   output logic [W-1:0]     result,
   output logic             wr_en,
   output logic             flag_cy,
   output logic             flag_ov,
   output logic             flag_s,
   output logic             flag_z,
   output logic             flag_sat
);

   localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] opnd_a, opnd_b, clamped;
   logic         do_sub, known_op, carry_raw, ovf_raw, active, sat_stored;
   sat_flags_t   flags;

   sat_operand_sel #(.W(W), .IMM_S(IMM_S), .IMM_L(IMM_L)) u_sel (
      .opcode    (opcode),
      .reg1_val  (reg1_val),
      .reg2_val  (reg2_val),
      .imm_short (imm_short),
      .imm_long  (imm_long),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .do_sub    (do_sub),
      .known_op  (known_op)
   );

   sat_addsub_core #(.W(W)) u_core (
      .opnd_a     (opnd_a),
      .opnd_b     (opnd_b),
      .do_sub     (do_sub),
      .clamped    (clamped),
      .carry_flag (carry_raw),
      .overflow   (ovf_raw)
   );

   assign active = op_valid & known_op;

   always_comb begin
      flags = '0;
      if (active) begin
         flags.cy = carry_raw;
         flags.ov = ovf_raw;
         flags.s  = clamped[W-1];
         flags.z  = (clamped == '0);
      end
   end

   sat_sticky_flag u_sticky (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_sat),
      .set_ev    (flags.ov),
      .flag_next (flag_sat),
      .flag_q    (sat_stored)
   );

   assign result  = active ? clamped : '0;
   assign wr_en   = active;
   assign flag_cy = flags.cy;
   assign flag_ov = flags.ov;
   assign flag_s  = flags.s;
   assign flag_z  = flags.z;

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (!wr_en && result == '0 && !flag_ov));

   // R6
   clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_ov |-> (result == POS_LIMIT || result == NEG_LIMIT));

   // R10
   sat_follows_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_ov |-> flag_sat);

   // R8
   zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (flag_z == (result == '0) && flag_s == result[W-1]));

   // R10
   sticky_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sat_stored |-> (flag_sat || clr_sat));

endmodule

// File: tb/sim_sat_arith_unit.sv
module sim_sat_arith_unit;

   localparam int CLK_P = 10;

   typedef struct packed {
      logic [5:0]  op;
      logic [31:0] r1;
      logic [31:0] r2;
      logic [4:0]  i5;
      logic [15:0] i16;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{6'b000110, 32'h0000_0005, 32'h0000_0007, 5'h00, 16'h0000, 32'h0000_000C}, // R1
      '{6'b000110, 32'h0000_0001, 32'h7FFF_FFFF, 5'h00, 16'h0000, 32'h7FFF_FFFF}, // R1 R6
      '{6'b000110, 32'h8000_0000, 32'hFFFF_FFFF, 5'h00, 16'h0000, 32'h8000_0000}, // R1 R6 R7
      '{6'b010001, 32'h0000_0000, 32'h0000_0000, 5'h1F, 16'h0000, 32'hFFFF_FFFF}, // R2 R8
      '{6'b010001, 32'h0000_0000, 32'h0000_0010, 5'h10, 16'h0000, 32'h0000_0000}, // R2 R7 R8
      '{6'b000101, 32'h0000_0005, 32'h0000_0003, 5'h00, 16'h0000, 32'hFFFF_FFFE}, // R3 R7
      '{6'b000101, 32'h0000_0001, 32'h8000_0000, 5'h00, 16'h0000, 32'h8000_0000}, // R3 R6
      '{6'b000100, 32'h0000_0010, 32'h0000_0003, 5'h00, 16'h0000, 32'h0000_000D}, // R4
      '{6'b000100, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'h00, 16'h0000, 32'h7FFF_FFFF}, // R4 R6
      '{6'b110011, 32'h0000_0100, 32'h0000_0000, 5'h00, 16'h8000, 32'h0000_8100}, // R5
      '{6'b110011, 32'h8000_0005, 32'h0000_0000, 5'h00, 16'h0007, 32'h8000_0000}, // R5 R6
      '{6'b000101, 32'h0000_0042, 32'h0000_0042, 5'h00, 16'h0000, 32'h0000_0000}  // R3 R8
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [5:0]  opcode = '0;
   logic [31:0] reg1_val = '0, reg2_val = '0;
   logic [4:0]  imm_short = '0;
   logic [15:0] imm_long = '0;
   logic        clr_sat = 1'b0;
   logic [31:0] result;
   logic        wr_en, flag_cy, flag_ov, flag_s, flag_z, flag_sat;

   int n_chk = 0;
   int n_bad = 0;
   logic exp_q = 1'b0;
   logic exp_next = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   sat_arith_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
      .reg1_val(reg1_val), .reg2_val(reg2_val), .imm_short(imm_short),
      .imm_long(imm_long), .clr_sat(clr_sat), .result(result), .wr_en(wr_en),
      .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_s(flag_s), .flag_z(flag_z),
      .flag_sat(flag_sat)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference in wide signed arithmetic: returns {cy, ov, result}
   function automatic logic [33:0] ref_op(input logic [5:0] op, input logic [31:0] r1,
                                          input logic [31:0] r2, input logic [4:0] i5,
                                          input logic [15:0] i16);
      longint a, b, raw;
      longint unsigned ua, ub;
      logic sub, cy, ov;
      logic [31:0] res;
      sub = 1'b0; a = 0; b = 0;
      case (op)
         6'b000110: begin a = longint'($signed(r2)); b = longint'($signed(r1)); end
         6'b010001: begin a = longint'($signed(r2)); b = longint'($signed(i5)); end
         6'b000101: begin a = longint'($signed(r2)); b = longint'($signed(r1)); sub = 1'b1; end
         6'b000100: begin a = longint'($signed(r1)); b = longint'($signed(r2)); sub = 1'b1; end
         default:   begin a = longint'($signed(r1)); b = longint'($signed(i16)); sub = 1'b1; end
      endcase
      ua = longint'(a) & 64'hFFFF_FFFF;
      ub = longint'(b) & 64'hFFFF_FFFF;
      raw = sub ? a - b : a + b;
      cy  = sub ? (ua < ub) : (((ua + ub) >> 32) != 0);
      ov  = 1'b1;
      if (raw > 64'sd2147483647)       res = 32'h7FFF_FFFF;
      else if (raw < -64'sd2147483648) res = 32'h8000_0000;
      else begin res = raw[31:0]; ov = 1'b0; end
      return {cy, ov, res};
   endfunction

   task automatic drive(input logic v, input logic [5:0] op, input logic [31:0] r1,
                        input logic [31:0] r2, input logic [4:0] i5,
                        input logic [15:0] i16, input logic clr);
      @(negedge clk);
      exp_q = exp_next;
      op_valid = v; opcode = op; reg1_val = r1; reg2_val = r2;
      imm_short = i5; imm_long = i16; clr_sat = clr;
      #1;
   endtask

   task automatic idle_chk(input string tag, input logic sat_exp);
      drive(1'b0, 6'b000000, '0, '0, '0, '0, 1'b0);
      exp_next = sat_exp;
      chk(tag, {31'b0, flag_sat}, {31'b0, sat_exp});
   endtask

   initial begin
      #(CLK_P*100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [33:0] m;
      repeat (3) @(posedge clk);
      #1;
      // R9 R10: reset state
      chk("R10 reset flag_sat", {31'b0, flag_sat}, 32'h0);
      chk("R9 reset wr_en", {31'b0, wr_en}, 32'h0);
      chk("R9 reset result", result, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(1'b1, VECS[i].op, VECS[i].r1, VECS[i].r2, VECS[i].i5, VECS[i].i16, 1'b0);
         m = ref_op(VECS[i].op, VECS[i].r1, VECS[i].r2, VECS[i].i5, VECS[i].i16);
         exp_next = exp_q | m[32];
         chk($sformatf("R1-5 vec%0d result", i), result, VECS[i].exp);
         chk($sformatf("R6 vec%0d ov", i), {31'b0, flag_ov}, {31'b0, m[32]});
         chk($sformatf("R7 vec%0d cy", i), {31'b0, flag_cy}, {31'b0, m[33]});
         chk($sformatf("R8 vec%0d s", i), {31'b0, flag_s}, {31'b0, VECS[i].exp[31]});
         chk($sformatf("R8 vec%0d z", i), {31'b0, flag_z}, {31'b0, VECS[i].exp == 0});
         chk($sformatf("R9 vec%0d wr_en", i), {31'b0, wr_en}, 32'h1);
         chk($sformatf("R10 vec%0d sat", i), {31'b0, flag_sat}, {31'b0, exp_next});
      end

      // R10: sticky across idle cycles
      idle_chk("R10 sticky idle 1", 1'b1);
      idle_chk("R10 sticky idle 2", 1'b1);

      // R11: clear alone
      drive(1'b0, 6'b000000, '0, '0, '0, '0, 1'b1);
      exp_next = 1'b0;
      chk("R11 clear same cycle", {31'b0, flag_sat}, 32'h0);
      idle_chk("R11 clear stored", 1'b0);

      // R9: unknown opcode with overflowing operands
      drive(1'b1, 6'b000111, 32'h1, 32'h7FFF_FFFF, '0, '0, 1'b0);
      exp_next = 1'b0;
      chk("R9 unknown wr_en", {31'b0, wr_en}, 32'h0);
      chk("R9 unknown result", result, 32'h0);
      chk("R9 unknown ov", {31'b0, flag_ov}, 32'h0);
      chk("R9 unknown cy", {31'b0, flag_cy}, 32'h0);
      idle_chk("R9 unknown no sat", 1'b0);

      // R9: valid low with overflowing add
      drive(1'b0, 6'b000110, 32'h1, 32'h7FFF_FFFF, '0, '0, 1'b0);
      exp_next = 1'b0;
      chk("R9 invalid wr_en", {31'b0, wr_en}, 32'h0);
      chk("R9 invalid result", result, 32'h0);
      idle_chk("R9 invalid no sat", 1'b0);

      // R11: clear and saturation collide, saturation wins
      drive(1'b0, 6'b000000, '0, '0, '0, '0, 1'b0);
      drive(1'b1, 6'b000110, 32'h1, 32'h7FFF_FFFF, '0, '0, 1'b0);
      exp_next = 1'b1;
      drive(1'b1, 6'b000110, 32'h8000_0000, 32'h8000_0000, '0, '0, 1'b1);
      exp_next = 1'b1;
      chk("R11 collide result", result, 32'h8000_0000);
      chk("R11 collide sat now", {31'b0, flag_sat}, 32'h1);
      idle_chk("R11 collide sat kept", 1'b1);

      // R11: clear with a non-saturating op
      drive(1'b1, 6'b000110, 32'h2, 32'h3, '0, '0, 1'b1);
      exp_next = 1'b0;
      chk("R11 clear+op result", result, 32'h5);
      chk("R11 clear+op sat now", {31'b0, flag_sat}, 32'h0);
      idle_chk("R11 clear+op stored", 1'b0);

      // R10: reset drops a set flag
      drive(1'b1, 6'b000101, 32'h1, 32'h8000_0000, '0, '0, 1'b0);
      exp_next = 1'b1;
      idle_chk("R10 set before reset", 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R10 reset clears sat", {31'b0, flag_sat}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_next = 1'b0;
      idle_chk("R10 after reset", 1'b0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule